// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block drives the repeated start of an I2C master. It lets the master turn the transfer direction around without giving up the bus. The surrounding controller reports whether it is currently the bus master and raises a one-cycle restart request. The sequencer then lets the bus go. It first lets SDA float high while it still holds SCL low, and then it lets SCL go. It never produces a stop, so other devices still see the bus as occupied.

Next it waits for its own bus-occupied flag to clear and for the released lines to come back high through two-flop synchronizers. A clock line that another device holds low keeps it waiting. It then times the repeated-start setup interval, latches the slave address and direction byte, and selects acknowledge mode. It pulls SDA low while SCL is high, holds that for the start hold time, and then pulls SCL low. At that point it sets the master, transmit, bus-occupied and interrupt-pending flags together.

The states are IDLE, RELEASE, WAIT_BB, WAIT_SCL, SETUP, LOAD, START and FINISH. The transitions are:
- IDLE→RELEASE on an accepted request.
- RELEASE→WAIT_BB after one cycle.
- WAIT_BB→WAIT_SCL once the flag is clear and the synchronizer settle count has expired.
- WAIT_SCL→SETUP once both synchronized lines read high.
- SETUP→LOAD when the setup count expires.
- LOAD→START after one cycle.
- START→FINISH when the hold count expires.
- FINISH→IDLE after one cycle.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, done, mst_o, trx_o, bb_o and pin_o are all 0, and the lines are released.
- R2: A restart_req while is_master is 0 is ignored. busy stays 0 and both line drives keep their values.
- R3: An accepted request raises busy from the next cycle until done. While busy, mst_o, trx_o and bb_o read 0 and pin_o reads 1.
- R4: During the sequence, SDA never rises while SCL is high and was high in the previous cycle. No stop condition is produced.
- R5: The start is not driven until bb_o is 0 and both synchronized lines read high. While another device holds SCL low, sda_oe stays 0.
- R6: SCL and SDA are both high for at least SETUP_CYC = ceil(4.7 µs × CLK_HZ) cycles (188 at 40 MHz) before SDA is pulled low.
- R7: Before the start, tx_byte takes the value of addr_dir and ack_sel becomes 1.
- R8: The start holds SDA low with SCL high for exactly HOLD_CYC = ceil(4.0 µs × CLK_HZ) cycles (160 at 40 MHz). After that, SCL is pulled low (scl_oe=1).
- R9: done is a single-cycle pulse. In the cycle after it, busy is 0, mst_o, trx_o, bb_o and pin_o are all 1, and scl_oe and sda_oe both stay 1.
- R10: A request that arrives while busy, including one in the done cycle, has no effect. No second sequence starts and no second done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | Controller is currently bus master |
| restart_req | input | 1 | One-cycle repeated-start request |
| addr_dir | input | 8 | Slave address (7:1) and direction bit (0) |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| mst_o | output | 1 | Master control flag |
| trx_o | output | 1 | Transmit control flag |
| bb_o | output | 1 | Bus-occupied control flag |
| pin_o | output | 1 | Interrupt-pending control flag |
| ack_sel | output | 1 | Acknowledge mode selected |
| tx_byte | output | 8 | Latched address and direction byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A fresh restart request can arrive in the same cycle as the completion pulse. The bench provokes this by watching for done at the falling edge and raising restart_req in that same cycle. It then expects busy to stay low and no further done pulse to appear. A second collision is a request raised in the middle of the setup wait. For that case the bench expects a single done and a byte that is not disturbed. The bench also releases an externally held SCL only after the flag has already cleared, and judges that the setup interval counts from the line going high.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_WAIT_BB,
        ST_WAIT_SCL,
        ST_SETUP,
        ST_LOAD,
        ST_START,
        ST_FINISH
    } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], d_in[b]};
            end
        end
        assign q_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_rs_timer.sv
module i2c_rs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter int SETUP_CYC   = 188,
    parameter int HOLD_CYC    = 160,
    parameter int SYNC_STAGES = 2,
    parameter int TW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          restart_req,
    input  logic [7:0]    addr_dir,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          tmr_exp,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          mst_o,
    output logic          trx_o,
    output logic          bb_o,
    output logic          pin_o,
    output logic          ack_sel,
    output logic [7:0]    tx_byte,
    output logic          busy,
    output logic          done
);
    rs_state_e state, nxt;
    logic      scl_keep, sda_keep;
    logic      accept;

    assign accept = (state == ST_IDLE) && restart_req && is_master;

    // next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt      = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SYNC_STAGES);
                end
            end
            ST_RELEASE:  nxt = ST_WAIT_BB;
            ST_WAIT_BB: begin
                if (tmr_exp && !bb_o) nxt = ST_WAIT_SCL;
            end
            ST_WAIT_SCL: begin
                if (scl_s && sda_s) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_exp) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                nxt      = ST_START;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            ST_START: begin
                if (tmr_exp) nxt = ST_FINISH;
            end
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // control flags, latched byte and held line drives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_o    <= 1'b0;
            trx_o    <= 1'b0;
            bb_o     <= 1'b0;
            pin_o    <= 1'b0;
            ack_sel  <= 1'b0;
            tx_byte  <= '0;
            scl_keep <= 1'b0;
            sda_keep <= 1'b0;
        end else begin
            if (accept) begin
                mst_o   <= 1'b0;
                trx_o   <= 1'b0;
                bb_o    <= 1'b0;
                pin_o   <= 1'b1;
                ack_sel <= 1'b0;
            end
            if (state == ST_LOAD) begin
                tx_byte <= addr_dir;
                ack_sel <= 1'b1;
            end
            if (state == ST_FINISH) begin
                mst_o    <= 1'b1;
                trx_o    <= 1'b1;
                bb_o     <= 1'b1;
                pin_o    <= 1'b1;
                scl_keep <= 1'b1;
                sda_keep <= 1'b1;
            end
        end
    end

    // line drives and status
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                scl_oe = scl_keep;
                sda_oe = sda_keep;
            end
            ST_RELEASE: scl_oe = scl_keep;
            ST_START:   sda_oe = 1'b1;
            ST_FINISH: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

    // R2
    ignore_not_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && restart_req && !is_master) |=> !busy);

    // R3
    flags_during_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mst_o && !trx_o && !bb_o && pin_o));

    // R4
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (scl_oe || $past(scl_oe)));

    // R8
    start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(sda_oe));

    // R9
    done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && mst_o && pin_o));

    // R5
    start_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(sda_oe)) |-> !bb_o);
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
    parameter int CLK_HZ      = 40_000_000,
    parameter int SETUP_NS    = 4700,
    parameter int HOLD_NS     = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master,
    input  logic       restart_req,
    input  logic [7:0] addr_dir,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       mst_o,
    output logic       trx_o,
    output logic       bb_o,
    output logic       pin_o,
    output logic       ack_sel,
    output logic [7:0] tx_byte,
    output logic       busy,
    output logic       done
);
    localparam int KHZ       = CLK_HZ / 1000;
    localparam int SETUP_CYC = (KHZ * SETUP_NS + 999_999) / 1_000_000;
    localparam int HOLD_CYC  = (KHZ * HOLD_NS + 999_999) / 1_000_000;
    localparam int MAX_A     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAXC      = (MAX_A > SYNC_STAGES) ? MAX_A : SYNC_STAGES;
    localparam int TW        = $clog2(MAXC + 1);

    logic [1:0]    lines_s;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;

    i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sda_in, scl_in}),
        .q_out (lines_s)
    );

    i2c_rs_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    i2c_rs_fsm #(
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .SYNC_STAGES (SYNC_STAGES),
        .TW          (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_master   (is_master),
        .restart_req (restart_req),
        .addr_dir    (addr_dir),
        .scl_s       (lines_s[0]),
        .sda_s       (lines_s[1]),
        .tmr_exp     (tmr_exp),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .mst_o       (mst_o),
        .trx_o       (trx_o),
        .bb_o        (bb_o),
        .pin_o       (pin_o),
        .ack_sel     (ack_sel),
        .tx_byte     (tx_byte),
        .busy        (busy),
        .done        (done)
    );
endmodule

// File: tb/i2c_rstart_seq_test.sv
module i2c_rstart_seq_test;
    localparam int EXP_SETUP = 188;
    localparam int EXP_HOLD  = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b0;
    logic       restart_req = 1'b0;
    logic [7:0] addr_dir = 8'h00;
    logic       ext_low = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_oe, sda_oe, mst_o, trx_o, bb_o, pin_o, ack_sel, busy, done;
    logic [7:0] tx_byte;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign scl_in = !(scl_oe || ext_low);
    assign sda_in = !sda_oe;

    i2c_rstart_seq uut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .restart_req(restart_req),
        .addr_dir(addr_dir), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .mst_o(mst_o), .trx_o(trx_o), .bb_o(bb_o), .pin_o(pin_o),
        .ack_sel(ack_sel), .tx_byte(tx_byte), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        // R1
        chk(scl_oe == 0 && sda_oe == 0, "R1 line drives", {scl_oe, sda_oe}, 0);
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk({mst_o, trx_o, bb_o, pin_o} == 4'b0, "R1 flags", {mst_o, trx_o, bb_o, pin_o}, 0);
    endtask

    task automatic t_not_master();
        bit ok = 1;
        // R2
        is_master = 0;
        @(negedge clk); restart_req = 1;
        @(negedge clk); restart_req = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy || scl_oe || sda_oe) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R2 request ignored outside master mode", {busy, scl_oe, sda_oe}, 0);
        chk({mst_o, trx_o, bb_o, pin_o} == 4'b0, "R2 flags untouched", {mst_o, trx_o, bb_o, pin_o}, 0);
    endtask

    task automatic run_restart(input logic [7:0] a, input int ext_hold,
                               input int extra_req_at, input bit req_at_done, input string tag);
        int  cyc = 0;
        int  setup_run = 0;
        int  setup_seen = -1;
        int  hold_run = 0;
        bit  busy_ok = 1, nostop = 1, ext_ok = 1, flag_ok = 1, quiet = 1;
        bit  prev_scl, prev_sda;
        bit  got_done = 0;
        $display("scenario %s", tag);
        addr_dir  = a;
        is_master = 1;
        if (ext_hold > 0) ext_low = 1;
        @(negedge clk); restart_req = 1;
        @(negedge clk); restart_req = 0;
        prev_scl = scl_in;
        prev_sda = sda_in;
        while (!got_done && cyc < 3000) begin
            if (!busy) busy_ok = 0;
            if (!done && (mst_o || trx_o || bb_o || !pin_o)) flag_ok = 0;
            if (ext_low && sda_oe) ext_ok = 0;
            if (scl_in && prev_scl && sda_in && !prev_sda) nostop = 0;
            if (prev_sda && !sda_in && setup_seen < 0) setup_seen = setup_run;
            if (scl_in && sda_in) setup_run++;
            else if (!scl_in) setup_run = 0;
            if (scl_in && !sda_in) hold_run++;
            if (done) got_done = 1;
            prev_scl = scl_in;
            prev_sda = sda_in;
            cyc++;
            if (cyc == ext_hold) ext_low = 0;
            restart_req = (cyc == extra_req_at);
            if (!got_done) @(negedge clk);
        end
        restart_req = 0;
        chk(got_done, "R9 done reached", got_done, 1);
        chk(busy_ok, "R3 busy held until done", busy_ok, 1);
        chk(flag_ok, "R3 flags cleared with pin set while busy", flag_ok, 1);
        chk(nostop, "R4 no stop condition", nostop, 1);
        if (ext_hold > 0) chk(ext_ok, "R5 no start while SCL held low", ext_ok, 1);
        chk(setup_seen >= EXP_SETUP && setup_seen <= EXP_SETUP + 8,
            "R6 setup interval", setup_seen, EXP_SETUP);
        chk(hold_run == EXP_HOLD, "R8 start hold", hold_run, EXP_HOLD);
        chk(tx_byte == a, "R7 address byte", tx_byte, a);
        chk(ack_sel == 1, "R7 ack mode", ack_sel, 1);
        if (req_at_done) restart_req = 1;
        @(negedge clk);
        restart_req = 0;
        chk(!busy && !done, "R9 pulse ends", {busy, done}, 0);
        chk({mst_o, trx_o, bb_o, pin_o} == 4'hF, "R9 flags set", {mst_o, trx_o, bb_o, pin_o}, 15);
        chk(scl_oe && sda_oe, "R9 lines held low", {scl_oe, sda_oe}, 3);
        for (int i = 0; i < 12; i++) begin
            if (busy || done) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R10 no second sequence", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_not_master();
        run_restart(8'hA5, 0, -1, 0, "plain restart");
        run_restart(8'h3C, 120, -1, 0, "clock held by another device");
        run_restart(8'h81, 0, 60, 1, "requests while busy and on done");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule